// File: doc/BRIEF.md
# Call/Return Frame Sequencer

This block performs the memory side of a subroutine call or return for a small processor core. On a call it builds a three-word frame below the current stack pointer. The highest word is a static-chain slot that is reserved but never written. The middle word holds the return address. The lowest word holds the caller's frame pointer. The new stack pointer and frame pointer both end up at that lowest word, and the program counter moves to the call target. A return walks the same frame back, starting from the frame pointer, and does not use the stack pointer.

The surrounding core decodes the instruction and owns the register file. It presents the current PC, the resolved target and the current SP and FP with a one-cycle `start` strobe. The block then issues word accesses over a simple request/ready memory port, one at a time. When the operation ends, `done` pulses for one cycle. At that point `sp_out`, `fp_out` and `pc_out` hold the values the core writes back. If `err` is high with `done`, those three outputs are simply the original SP, FP and PC.

Top module: `frame_seq`

## Requirements
- R1: During a call the static-chain word at SP-4 is never written.
- R2: A call first writes the return address to SP-8. The return address is PC+6 when `abs_call`=1 (absolute 6-byte form) and PC+2 when `abs_call`=0 (register 2-byte form).
- R3: A call writes the old FP to SP-12, and only after the return-address write has been accepted. A call makes exactly two writes.
- R4: After a successful call, `sp_out` = `fp_out` = SP-12 and `pc_out` = `tgt`.
- R5: A return (`is_ret`=1) reads the saved FP from address FP, then the return address from FP+4, and makes no writes. After it, `fp_out` = the first word read, `pc_out` = the second word read, and `sp_out` = FP+12.
- R6: Each access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is high on a clock edge. The sequence waits for as many cycles as the memory needs.
- R7: An access accepted with `mem_fault`=1 ends the sequence with no further access. `done` and `err` are then asserted, and `sp_out`/`fp_out`/`pc_out` equal the SP, FP and PC given at `start`. `err` stays high until the next `start`.
- R8: `busy` is high from the cycle after `start` is sampled until `done`. `done` lasts one cycle, and `busy` is low in the cycle after it.
- R9: A `start` pulse while `busy` is high is ignored. It does not change the results and does not launch a second operation.
- R10: While `rst_n` is low and just after reset, `busy`, `done`, `err` and `mem_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| is_ret | input | 1 | 1 = return, 0 = call |
| abs_call | input | 1 | For a call: 1 = 6-byte absolute form, 0 = 2-byte register form |
| cur_pc | input | W | PC of the call/return instruction |
| tgt | input | W | Resolved call target |
| sp_in | input | W | Current stack pointer |
| fp_in | input | W | Current frame pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | W | Byte address of the word accessed |
| mem_wdata | output | W | Write data |
| mem_ready | input | 1 | Access accepted on this edge |
| mem_fault | input | 1 | Accepted access faulted (valid with `mem_ready`) |
| mem_rdata | input | W | Read data (valid with `mem_ready`) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation aborted on a fault |
| sp_out | output | W | Resulting stack pointer |
| fp_out | output | W | Resulting frame pointer |
| pc_out | output | W | Resulting program counter |

## Verification
The bench sweeps memory latencies of zero to two wait cycles. It uses stack addresses near both ends of a small memory, both call forms, returns, and faults on each individual access. The memory is filled with a sentinel beforehand, so a design that touched the static-chain slot, swapped the two pushes or pushed at the wrong offset would leave the wrong words in the wrong places. An off-by-four return address shows up directly in memory. A return computed from SP instead of FP shows up as a wrong `sp_out`. A design that kept going after a fault, or committed half of the frame, would show extra accesses or changed outputs next to `err`. A second `start` pulse during a slow access exposes a sequencer that re-latches its inputs while busy.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_ret,
  input  logic         abs_call,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] fp_in,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ready,
  input  logic         mem_fault,
  input  logic [W-1:0] mem_rdata,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] fp_out,
  output logic [W-1:0] pc_out
);
  localparam logic [W-1:0] WB      = W'(W / 8);
  localparam logic [W-1:0] LEN_ABS = W'(6);
  localparam logic [W-1:0] LEN_REG = W'(2);

  typedef enum logic [2:0] {S_IDLE, S_WRA, S_WFP, S_RFP, S_RRA, S_FIN} st_t;
  st_t st;

  logic [W-1:0] base, ra_q, tgt_q, fsave, sp_q, fp_q, pc_q;
  logic         err_q, ret_q;

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign err     = err_q;
  assign sp_out  = sp_q;
  assign fp_out  = fp_q;
  assign pc_out  = pc_q;
  assign mem_req = (st == S_WRA) || (st == S_WFP) || (st == S_RFP) || (st == S_RRA);
  assign mem_we  = (st == S_WRA) || (st == S_WFP);
  assign mem_wdata = (st == S_WRA) ? ra_q : fsave;

  always_comb begin
    case (st)
      S_WRA:   mem_addr = base - 2 * WB;
      S_WFP:   mem_addr = base - 3 * WB;
      S_RRA:   mem_addr = base + WB;
      default: mem_addr = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base <= '0; ra_q <= '0; tgt_q <= '0; fsave <= '0;
      sp_q <= '0; fp_q <= '0; pc_q <= '0;
      err_q <= 1'b0; ret_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base  <= is_ret ? fp_in : sp_in;
          ra_q  <= cur_pc + (abs_call ? LEN_ABS : LEN_REG);
          tgt_q <= tgt;
          fsave <= fp_in;
          sp_q  <= sp_in;
          fp_q  <= fp_in;
          pc_q  <= cur_pc;
          err_q <= 1'b0;
          ret_q <= is_ret;
          st    <= is_ret ? S_RFP : S_WRA;
        end
        S_FIN: st <= S_IDLE;
        default: if (mem_ready) begin
          if (mem_fault) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            case (st)
              S_WRA: st <= S_WFP;
              S_WFP: begin
                sp_q <= base - 3 * WB;
                fp_q <= base - 3 * WB;
                pc_q <= tgt_q;
                st   <= S_FIN;
              end
              S_RFP: begin
                fsave <= mem_rdata;
                st    <= S_RRA;
              end
              default: begin
                pc_q <= mem_rdata;
                fp_q <= fsave;
                sp_q <= base + 3 * WB;
                st   <= S_FIN;
              end
            endcase
          end
        end
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && mem_fault |=> !mem_req && done && err);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R4
  call_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && !ret_q |-> sp_out == fp_out);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy && !done |-> $stable(sp_out) && $stable(fp_out) && $stable(pc_out));
endmodule

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  localparam int W = 32;
  localparam logic [W-1:0] SENT = 32'hDEAD_BEEF;

  logic clk = 0, rst_n = 0, start = 0, is_ret = 0, abs_call = 0;
  logic [W-1:0] cur_pc = '0, tgt = '0, sp_in = '0, fp_in = '0;
  logic mem_req, mem_we, mem_ready = 0, mem_fault = 0;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic busy, done, err;
  logic [W-1:0] sp_out, fp_out, pc_out;

  frame_seq #(.W(W)) u0 (.*);

  always #5 clk = ~clk;

  logic [W-1:0] mem [256];
  logic [W-1:0] wlog [4];
  int nw = 0, nacc = 0, lat = 0, waitc = 0;
  logic [W-1:0] fault_addr = '1;
  int checks = 0, fails = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (waitc >= lat) begin
        mem_ready = 1;
        mem_fault = (mem_addr == fault_addr);
        mem_rdata = mem[mem_addr[9:2]];
        nacc++;
        if (mem_we && !mem_fault) begin
          mem[mem_addr[9:2]] = mem_wdata;
          if (nw < 4) wlog[nw] = mem_addr;
          nw++;
        end
        waitc = 0;
      end else begin
        mem_ready = 0; mem_fault = 0;
        waitc++;
      end
    end else begin
      mem_ready = 0; mem_fault = 0;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // runs one operation; poke=1 fires a junk start while busy
  task automatic run_op(input bit ret, input bit ab, input logic [W-1:0] pc,
                        input logic [W-1:0] tg, input logic [W-1:0] sp,
                        input logic [W-1:0] fp, input bit poke);
    int guard;
    nw = 0; nacc = 0; waitc = 0;
    @(negedge clk);
    start = 1; is_ret = ret; abs_call = ab; cur_pc = pc; tgt = tg; sp_in = sp; fp_in = fp;
    @(negedge clk);
    start = 0;
    chk("R8 busy after start", W'(busy), 1);
    guard = 0;
    while (!done && guard < 60) begin
      if (poke && guard == 0) begin
        start = 1; is_ret = ~ret; cur_pc = 32'h1111_1111; tgt = 32'h2222_2222;
        sp_in = 32'h40; fp_in = 32'h80;
      end
      if (poke && guard == 1) start = 0;
      @(negedge clk);
      guard++;
    end
    start = 0;
    chk("R8 done reached", W'(done), 1);
  endtask

  initial begin
    logic [W-1:0] sp, fp, pc, tg, ra, sfp, sra;
    repeat (3) @(negedge clk);
    // R10
    chk("R10 busy in reset", W'(busy), 0);
    chk("R10 mem_req in reset", W'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 done after reset", W'(done), 0);
    chk("R10 err after reset", W'(err), 0);

    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int s = 0; s < 2; s++) begin
        sp = (s == 0) ? 32'h0000_0010 : 32'h0000_03F0;
        fp = 32'h0000_0100 + 32'(s * 4);
        for (int ab = 0; ab < 2; ab++) begin
          for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < 256; i++) mem[i] = SENT;
            pc = 32'h0000_1000 + 32'(l * 16 + ab * 8);
            tg = 32'h8000_0000 | sp;
            ra = pc + ((ab != 0) ? 32'd6 : 32'd2);
            fault_addr = (f == 1) ? sp - 8 : (f == 2) ? sp - 12 : '1;
            run_op(0, ab[0], pc, tg, sp, fp, (l == 2 && f == 0));
            // R1
            chk("R1 static chain untouched", mem[(sp - 4) >> 2], SENT);
            if (f == 0) begin
              chk("R4 sp", sp_out, sp - 12);
              chk("R4 fp", fp_out, sp - 12);
              chk("R4 pc (R9 poke ignored)", pc_out, tg);
              chk("R7 no err", W'(err), 0);
              chk("R2 return address", mem[(sp - 8) >> 2], ra);
              chk("R3 saved fp", mem[(sp - 12) >> 2], fp);
              chk("R3 write count", W'(nw), 2);
              chk("R2 first write addr", wlog[0], sp - 8);
              chk("R3 second write addr", wlog[1], sp - 12);
            end else begin
              chk("R7 err", W'(err), 1);
              chk("R7 sp kept", sp_out, sp);
              chk("R7 fp kept", fp_out, fp);
              chk("R7 pc kept", pc_out, pc);
              chk("R7 access count", W'(nacc), W'(f));
              if (f == 1) chk("R7 no fp push", mem[(sp - 12) >> 2], SENT);
            end
            @(negedge clk);
            chk("R8 busy low after done", W'(busy), 0);
            chk("R8 done one cycle", W'(done), 0);
            if (f != 0) chk("R7 err held", W'(err), 1);
            chk("R9 no relaunch", W'(mem_req), 0);
          end
        end
      end
      for (int s = 0; s < 2; s++) begin
        fp = (s == 0) ? 32'h0000_0020 : 32'h0000_03E0;
        sp = 32'h0000_0300;
        for (int f = 0; f < 3; f++) begin
          for (int i = 0; i < 256; i++) mem[i] = SENT;
          sfp = fp ^ 32'h5A5A_0000;
          sra = 32'h0000_4000 + fp + 32'(l);
          mem[fp >> 2] = sfp;
          mem[(fp + 4) >> 2] = sra;
          pc = 32'h0000_2000 + 32'(l);
          fault_addr = (f == 1) ? fp : (f == 2) ? fp + 4 : '1;
          run_op(1, 0, pc, 32'h0, sp, fp, (l == 1 && f == 0));
          chk("R5 no writes", W'(nw), 0);
          if (f == 0) begin
            chk("R5 sp", sp_out, fp + 12);
            chk("R5 fp", fp_out, sfp);
            chk("R5 pc", pc_out, sra);
            chk("R5 two reads", W'(nacc), 2);
            chk("R5 no err", W'(err), 0);
          end else begin
            chk("R7 ret err", W'(err), 1);
            chk("R7 ret sp kept", sp_out, sp);
            chk("R7 ret fp kept", fp_out, fp);
            chk("R7 ret pc kept", pc_out, pc);
            chk("R7 ret access count", W'(nacc), W'(f));
          end
          @(negedge clk);
          chk("R8 ret busy low", W'(busy), 0);
        end
      end
    end
    fault_addr = '1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule